// File: doc/BRIEF.md
# Two-Bank Interleaved Memory Access Scheduler

This block takes a single in-order stream of 64-bit word requests from a processor and spreads them over two DRAM banks. The bank is chosen from the byte address at 8-byte granularity, so a run of consecutive words lands on alternate banks. While one bank is still recovering (precharging) from its last access, the other bank can already be accessed. A run of sequential words therefore moves at the rate set by the access time rather than the full access-plus-recovery cycle.

Each bank is a simple timed device. It sees a one-cycle command pulse with a word address, a write flag and write data. It is busy for `T_ACC` cycles of access and then `T_RP` cycles of recovery. The banks share one access path, so only one access runs at a time; recovery is the part that overlaps. A request whose target bank is not ready holds the request port with `req_ready` low. Requests are never reordered. Read data comes back with a valid pulse and the number of the bank that served it.

Top module: `ilv_sched`

## Requirements
- R1: Byte-address bit 3 picks the bank: 0 selects bank 0 (bytes 0-7, 16-23, 32-39, ...), 1 selects bank 1 (bytes 8-15, 24-31, ...). `rsp_bank` carries that bank number for each read.
- R2: A request accepted at clock edge k (req_valid and req_ready high) makes `bank_cmd_valid[b]` high for exactly the one cycle after edge k. In that cycle `bank_addr` = req_addr[ADDR_W-1:4], `bank_we` = req_we and `bank_wdata` = req_wdata.
- R3: After an accept to a bank at edge k, `req_ready` stays low for requests to that bank until edge k+T_ACC+T_RP. With req_valid held, back-to-back requests to one bank are accepted exactly T_ACC+T_RP edges apart.
- R4: Only one access is in flight at a time. After an accept at edge k, a request to the other bank can be accepted no earlier than edge k+T_ACC. An alternating bank stream with valid held is accepted every T_ACC edges (for T_RP <= T_ACC).
- R5: A read accepted at edge k gives `rsp_valid` high for the one cycle after edge k+T_ACC. `rsp_data` holds the word the addressed bank returns. Writes give no response.
- R6: Responses appear in the same order as the read requests were accepted.
- R7: While reset is asserted, `bank_cmd_valid` and `rsp_valid` are low. Once reset has been released, with no traffic, `req_ready` is high for either bank.
- R8: Address bits 2:0 have no effect: any byte address within one 8-byte word reaches the same bank and word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Request accepted this edge when high with req_valid |
| req_addr | input | ADDR_W | Byte address |
| req_we | input | 1 | 1 = write, 0 = read |
| req_wdata | input | DATA_W | Write word |
| bank_cmd_valid | output | 2 | One-cycle command pulse, one bit per bank |
| bank_addr | output | ADDR_W-4 | Word address within the bank |
| bank_we | output | 1 | Command is a write |
| bank_wdata | output | DATA_W | Write word to bank |
| bank0_rdata | input | DATA_W | Read word from bank 0 |
| bank1_rdata | input | DATA_W | Read word from bank 1 |
| rsp_valid | output | 1 | Read response pulse |
| rsp_data | output | DATA_W | Read response word |
| rsp_bank | output | 1 | Bank that served the response |

## Verification
The assertions assume T_ACC of at least 2 and T_RP of at least 1. They also assume a bank's read word is stable from the cycle after its command until its access ends, and that no request is offered during the two cycles the internal reset takes to release. The bench models each bank as a memory that latches its read word on the command edge, which meets the stability assumption. It waits several cycles after reset before sending anything. The stimulus uses T_RP <= T_ACC, so the alternating-stream rate from R4 is reachable, and it holds each request steady until it is accepted.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  localparam int NBANK        = 2;
  localparam int BANK_SEL_BIT = 3;
  localparam int WORD_LSB     = BANK_SEL_BIT + 1;
  typedef logic [NBANK-1:0] bank_vec_t;
endpackage

// File: rtl/ilv_bank_timer.sv
module ilv_bank_timer #(
  parameter int T_ACC = 4,
  parameter int T_RP  = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic issue,
  input  logic issue_rd,
  output logic idle,
  output logic path_hold,
  output logic done_rd
);
  localparam int AW = $clog2(T_ACC + 1);
  localparam int PW = (T_RP > 1) ? $clog2(T_RP) : 1;

  logic [AW-1:0] acc_q, acc_d;
  logic [PW-1:0] pre_q, pre_d;
  logic          rd_q, rd_d;

  always_comb begin
    acc_d = acc_q;
    pre_d = pre_q;
    rd_d  = rd_q;
    if (issue) begin
      acc_d = AW'(T_ACC);
      rd_d  = issue_rd;
    end else if (acc_q != '0) begin
      acc_d = acc_q - 1'b1;
      if (acc_q == AW'(1)) pre_d = PW'(T_RP - 1);
    end else if (pre_q != '0) begin
      pre_d = pre_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc_q <= '0;
      pre_q <= '0;
      rd_q  <= 1'b0;
    end else begin
      acc_q <= acc_d;
      pre_q <= pre_d;
      rd_q  <= rd_d;
    end
  end

  assign idle      = (acc_q == '0) && (pre_q == '0);
  assign path_hold = (acc_q > AW'(1));
  assign done_rd   = (acc_q == AW'(1)) && rd_q;

  // R3: a bank is only given new work when fully recovered
  p_issue_when_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    issue |-> idle);
  // R3: recovery never overlaps the access phase of the same bank
  p_pre_after_acc_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (pre_q != '0) |-> (acc_q == '0));
endmodule

// File: rtl/ilv_issue.sv
module ilv_issue
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   req_valid,
  input  logic [ADDR_W-1:0]      req_addr,
  input  logic                   req_we,
  input  logic [DATA_W-1:0]      req_wdata,
  input  bank_vec_t              bank_idle,
  input  bank_vec_t              path_hold,
  output logic                   req_ready,
  output bank_vec_t              issue,
  output logic                   issue_rd,
  output bank_vec_t              cmd_valid,
  output logic [ADDR_W-WORD_LSB-1:0] cmd_addr,
  output logic                   cmd_we,
  output logic [DATA_W-1:0]      cmd_wdata
);
  logic                   tgt;
  logic                   fire;
  logic [2:0]             unused_byte_lane;

  assign tgt              = req_addr[BANK_SEL_BIT];
  assign unused_byte_lane = req_addr[2:0];
  assign req_ready        = bank_idle[tgt] && !(|path_hold);
  assign fire             = req_valid && req_ready;
  assign issue_rd         = !req_we;

  always_comb begin
    issue = '0;
    if (fire) issue[tgt] = 1'b1;
  end

  bank_vec_t                   vld_q;
  logic [ADDR_W-WORD_LSB-1:0]  addr_q;
  logic                        we_q;
  logic [DATA_W-1:0]           wdata_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q   <= '0;
      addr_q  <= '0;
      we_q    <= 1'b0;
      wdata_q <= '0;
    end else begin
      vld_q <= issue;
      if (fire) begin
        addr_q  <= req_addr[ADDR_W-1:WORD_LSB];
        we_q    <= req_we;
        wdata_q <= req_wdata;
      end
    end
  end

  assign cmd_valid = vld_q;
  assign cmd_addr  = addr_q;
  assign cmd_we    = we_q;
  assign cmd_wdata = wdata_q;

  // R2: a command reaches at most one bank per cycle
  p_one_cmd_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(cmd_valid));

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_pulse
      // R2: a bank command is a single-cycle pulse
      p_cmd_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cmd_valid[b] |=> !cmd_valid[b]);
    end
  endgenerate
endmodule

// File: rtl/ilv_resp.sv
module ilv_resp
  import ilv_pkg::*;
#(
  parameter int DATA_W = 64
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bank_vec_t         done_rd,
  input  logic [DATA_W-1:0] bank0_rdata,
  input  logic [DATA_W-1:0] bank1_rdata,
  output logic              rsp_valid,
  output logic [DATA_W-1:0] rsp_data,
  output logic              rsp_bank
);
  logic              any_done;
  logic              sel;
  logic [DATA_W-1:0] data_d;

  assign any_done = |done_rd;
  assign sel      = done_rd[1];
  assign data_d   = sel ? bank1_rdata : bank0_rdata;

  logic              vld_q;
  logic [DATA_W-1:0] data_q;
  logic              bank_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vld_q  <= 1'b0;
      data_q <= '0;
      bank_q <= 1'b0;
    end else begin
      vld_q <= any_done;
      if (any_done) begin
        data_q <= data_d;
        bank_q <= sel;
      end
    end
  end

  assign rsp_valid = vld_q;
  assign rsp_data  = data_q;
  assign rsp_bank  = bank_q;

  // R6: two reads never finish in the same cycle, so order is kept
  p_one_done_r6: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(done_rd));
endmodule

// File: rtl/ilv_sched.sv
module ilv_sched
  import ilv_pkg::*;
#(
  parameter int ADDR_W = 16,
  parameter int DATA_W = 64,
  parameter int T_ACC  = 4,
  parameter int T_RP   = 3
) (
  input  logic                       clk,
  input  logic                       rst_n,
  input  logic                       req_valid,
  output logic                       req_ready,
  input  logic [ADDR_W-1:0]          req_addr,
  input  logic                       req_we,
  input  logic [DATA_W-1:0]          req_wdata,
  output logic [1:0]                 bank_cmd_valid,
  output logic [ADDR_W-WORD_LSB-1:0] bank_addr,
  output logic                       bank_we,
  output logic [DATA_W-1:0]          bank_wdata,
  input  logic [DATA_W-1:0]          bank0_rdata,
  input  logic [DATA_W-1:0]          bank1_rdata,
  output logic                       rsp_valid,
  output logic [DATA_W-1:0]          rsp_data,
  output logic                       rsp_bank
);
  logic [1:0] rst_sync_q;
  logic       rst_core_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= '0;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_core_n = rst_sync_q[1];

  bank_vec_t issue, bank_idle, path_hold, done_rd;
  logic      issue_rd;

  ilv_issue #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_issue (
    .clk       (clk),
    .rst_n     (rst_core_n),
    .req_valid (req_valid),
    .req_addr  (req_addr),
    .req_we    (req_we),
    .req_wdata (req_wdata),
    .bank_idle (bank_idle),
    .path_hold (path_hold),
    .req_ready (req_ready),
    .issue     (issue),
    .issue_rd  (issue_rd),
    .cmd_valid (bank_cmd_valid),
    .cmd_addr  (bank_addr),
    .cmd_we    (bank_we),
    .cmd_wdata (bank_wdata)
  );

  generate
    for (genvar b = 0; b < NBANK; b++) begin : g_bank
      ilv_bank_timer #(.T_ACC(T_ACC), .T_RP(T_RP)) u_timer (
        .clk       (clk),
        .rst_n     (rst_core_n),
        .issue     (issue[b]),
        .issue_rd  (issue_rd),
        .idle      (bank_idle[b]),
        .path_hold (path_hold[b]),
        .done_rd   (done_rd[b])
      );
    end
  endgenerate

  ilv_resp #(.DATA_W(DATA_W)) u_resp (
    .clk         (clk),
    .rst_n       (rst_core_n),
    .done_rd     (done_rd),
    .bank0_rdata (bank0_rdata),
    .bank1_rdata (bank1_rdata),
    .rsp_valid   (rsp_valid),
    .rsp_data    (rsp_data),
    .rsp_bank    (rsp_bank)
  );

  // R4: the shared access path is held by at most one bank
  p_path_excl_r4: assert property (@(posedge clk) disable iff (!rst_core_n)
    $onehot0(path_hold));
  // R7: no bank command and no response while in reset
  p_quiet_reset_r7: assert property (@(posedge clk)
    !rst_core_n |-> (bank_cmd_valid == 2'b00) && !rsp_valid);
endmodule

// File: tb/ilv_sched_tb.sv
`timescale 1ns/100ps
module ilv_sched_tb;
  localparam int ADDR_W = 16;
  localparam int DATA_W = 64;
  localparam int T_ACC  = 4;
  localparam int T_RP   = 3;

  logic              clk = 1'b0;
  logic              rst_n;
  logic              req_valid;
  logic              req_ready;
  logic [ADDR_W-1:0] req_addr;
  logic              req_we;
  logic [DATA_W-1:0] req_wdata;
  logic [1:0]        bank_cmd_valid;
  logic [ADDR_W-5:0] bank_addr;
  logic              bank_we;
  logic [DATA_W-1:0] bank_wdata;
  logic [DATA_W-1:0] bank0_rdata, bank1_rdata;
  logic              rsp_valid;
  logic [DATA_W-1:0] rsp_data;
  logic              rsp_bank;

  always #2.5 clk = ~clk;

  ilv_sched #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .T_ACC(T_ACC), .T_RP(T_RP)) u_dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_addr(req_addr), .req_we(req_we), .req_wdata(req_wdata),
    .bank_cmd_valid(bank_cmd_valid), .bank_addr(bank_addr), .bank_we(bank_we),
    .bank_wdata(bank_wdata), .bank0_rdata(bank0_rdata), .bank1_rdata(bank1_rdata),
    .rsp_valid(rsp_valid), .rsp_data(rsp_data), .rsp_bank(rsp_bank)
  );

  function automatic logic [63:0] seed_word(int b, int i);
    return {32'hC3A50000 | (b << 8) | i, 32'(i * 32'h01010101) ^ 32'(b)};
  endfunction

  // timed bank models: latch read word on the command edge
  logic [63:0] bmem0 [0:63];
  logic [63:0] bmem1 [0:63];
  always @(posedge clk) begin
    if (bank_cmd_valid[0]) begin
      if (bank_we) bmem0[bank_addr[5:0]] <= bank_wdata;
      bank0_rdata <= bmem0[bank_addr[5:0]];
    end
    if (bank_cmd_valid[1]) begin
      if (bank_we) bmem1[bank_addr[5:0]] <= bank_wdata;
      bank1_rdata <= bmem1[bank_addr[5:0]];
    end
  end

  // bookkeeping
  int total = 0, bad = 0;
  bit finished = 0;
  int cyc;

  task automatic chk(bit ok, string req, string what, longint unsigned act, longint unsigned exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) cyc <= 0;
    else        cyc <= cyc + 1;
  end

  always @(posedge clk) begin
    if (rst_n && cyc > 20000) begin
      total++; bad++;
      $display("FAIL watchdog expired act=%0d exp=%0d", cyc, 20000);
      finish_run();
    end
  end

  // reference model
  logic [63:0] ref0 [0:63];
  logic [63:0] ref1 [0:63];
  int          bank_free [2];
  int          bus_free;
  int          last_acc_edge;
  int          last_acc_bank;
  logic [11:0] last_waddr;
  logic        last_we;
  logic [63:0] last_wdata;
  typedef struct { int due; logic [63:0] data; logic bank; } rsp_t;
  rsp_t        rq[$];
  int          acc_log[$];

  always @(negedge clk) begin
    if (!rst_n) begin
      chk(bank_cmd_valid == 2'b00, "R7", "cmd in reset", bank_cmd_valid, 0);
      chk(!rsp_valid, "R7", "rsp in reset", rsp_valid, 0);
      bank_free[0] = 0; bank_free[1] = 0; bus_free = 0;
      last_acc_edge = -1; rq.delete();
    end else begin
      // responses
      begin
        bit exp_rsp;
        exp_rsp = (rq.size() != 0) && (rq[0].due == cyc);
        chk(rsp_valid == exp_rsp, "R5", "rsp_valid", rsp_valid, exp_rsp);
        if (rsp_valid && exp_rsp) begin
          chk(rsp_data == rq[0].data, "R6", "rsp_data", rsp_data, rq[0].data);
          chk(rsp_bank == rq[0].bank, "R1", "rsp_bank", rsp_bank, rq[0].bank);
          void'(rq.pop_front());
        end
      end
      // bank commands
      begin
        logic [1:0] exp_cmd;
        exp_cmd = (last_acc_edge == cyc) ? (2'b01 << last_acc_bank) : 2'b00;
        chk(bank_cmd_valid == exp_cmd, "R2", "bank_cmd_valid", bank_cmd_valid, exp_cmd);
        if (exp_cmd != 2'b00) begin
          chk(bank_addr == last_waddr, "R2", "bank_addr", bank_addr, last_waddr);
          chk(bank_we == last_we, "R2", "bank_we", bank_we, last_we);
          if (last_we) chk(bank_wdata == last_wdata, "R2", "bank_wdata", bank_wdata, last_wdata);
        end
      end
      // ready and accept
      begin
        int  b, k;
        bit  exp_rdy;
        b = int'(req_addr[3]);
        k = cyc + 1;
        exp_rdy = (k >= bank_free[b]) && (k >= bus_free);
        chk(req_ready == exp_rdy, (k < bus_free) ? "R4" : "R3", "req_ready", req_ready, exp_rdy);
        if (req_valid && req_ready) begin
          bank_free[b]  = k + T_ACC + T_RP;
          bus_free      = k + T_ACC;
          last_acc_edge = k;
          last_acc_bank = b;
          last_waddr    = req_addr[15:4];
          last_we       = req_we;
          last_wdata    = req_wdata;
          acc_log.push_back(k);
          if (req_we) begin
            if (b == 0) ref0[req_addr[9:4]] = req_wdata;
            else        ref1[req_addr[9:4]] = req_wdata;
          end else begin
            rsp_t r;
            r.due  = k + T_ACC;
            r.data = (b == 0) ? ref0[req_addr[9:4]] : ref1[req_addr[9:4]];
            r.bank = req_addr[3];
            rq.push_back(r);
          end
        end
      end
    end
  end

  task automatic send(logic [15:0] a, logic we, logic [63:0] d);
    req_valid = 1'b1; req_addr = a; req_we = we; req_wdata = d;
    @(negedge clk);
    while (!req_ready) @(negedge clk);
    @(posedge clk); #1;
    req_valid = 1'b0;
  endtask

  task automatic check_spacing(int gap, string req);
    for (int i = 1; i < acc_log.size(); i++)
      chk(acc_log[i] - acc_log[i-1] == gap, req, "accept spacing",
          acc_log[i] - acc_log[i-1], gap);
  endtask

  task automatic drain();
    repeat (T_ACC + T_RP + 4) @(posedge clk);
    #1;
  endtask

  initial begin
    for (int i = 0; i < 64; i++) begin
      bmem0[i] = seed_word(0, i); ref0[i] = seed_word(0, i);
      bmem1[i] = seed_word(1, i); ref1[i] = seed_word(1, i);
    end
    rst_n = 1'b0; req_valid = 1'b0; req_addr = '0; req_we = 1'b0; req_wdata = '0;
    repeat (4) @(posedge clk);
    #1 rst_n = 1'b1;
    repeat (5) @(posedge clk);
    #1;
    // R7: idle ready for both banks
    @(negedge clk);
    chk(req_ready == 1'b1, "R7", "idle ready bank0", req_ready, 1);
    req_addr = 16'h0008; #0.1;
    chk(req_ready == 1'b1, "R7", "idle ready bank1", req_ready, 1);
    @(posedge clk); #1;

    // R4: alternating writes, one per T_ACC
    acc_log.delete();
    for (int i = 0; i < 8; i++) send(16'(i * 8), 1'b1, 64'hF00D_0000_0000_0000 | 64'(i));
    check_spacing(T_ACC, "R4");
    drain();

    // R4/R5/R6: alternating reads of the written words
    acc_log.delete();
    for (int i = 0; i < 8; i++) send(16'(i * 8), 1'b0, '0);
    check_spacing(T_ACC, "R4");
    drain();

    // R3: same-bank reads spaced by full cycle
    acc_log.delete();
    for (int i = 0; i < 4; i++) send(16'(i * 16 + 16'h0100), 1'b0, '0);
    check_spacing(T_ACC + T_RP, "R3");
    drain();
    acc_log.delete();
    for (int i = 0; i < 3; i++) send(16'(i * 16 + 16'h0208), 1'b0, '0);
    check_spacing(T_ACC + T_RP, "R3");
    drain();

    // R8: byte lanes within a word are ignored
    send(16'h0127, 1'b1, 64'h1234_5678_9ABC_DEF0);
    send(16'h013A, 1'b1, 64'h0FED_CBA9_8765_4321);
    send(16'h0121, 1'b0, '0);
    send(16'h0139, 1'b0, '0);
    send(16'h0126, 1'b0, '0);
    drain();

    // mixed traffic with gaps
    for (int i = 0; i < 40; i++) begin
      send(16'((i * 24 + (i % 8)) % 1024), (i % 3) == 0, 64'hAB00_0000_0000_0000 | 64'(i * 7));
      repeat (i % 2) @(posedge clk);
      #1;
    end
    drain();
    chk(rq.size() == 0, "R6", "responses outstanding", rq.size(), 0);
    finish_run();
  end
endmodule